// File: doc/BRIEF.md
# Show-Cycle Mirroring Bridge

The bridge sits beside a local processor bus and replays selected local accesses on an upstream bus as show cycles, so that an external debug tool can watch internal traffic. When a local access that qualifies begins, the bridge takes ownership of the local bus so no further local cycle can start. It captures the access's address, attributes, direction and write data. It then waits for the local data phase to end and records the read data and the error status.

With the capture complete, the bridge asks for the upstream bus. It presents the captured cycle as a show-cycle address phase and acknowledges that address phase itself. It then closes the upstream data phase with its own termination strobe and error flag, after which it gives the local bus back. An upstream no-show indicator makes it withdraw and ask again later. An inhibit input keeps it off the upstream bus entirely. Two mode enables, one for reads and one for writes, choose which local traffic is mirrored.

Top module: `showcyc_bridge`

## Requirements
- R1: While rstN is low and in the first cycle after it rises, lbHold, busy, upReq, upShow, upAddrAck and upDataAck are all 0.
- R2: A local access qualifies when lbValid is 1, lbTargetUp, lbTargetOwn and lbSpr are 0, and the enable for its direction is 1 (enWrite when lbWrite is 1, enRead otherwise). lbHold rises in the cycle after lbValid. It stays high through the cycle of upDataAck and is low in the cycle after it.
- R3: For each qualifying access that ends with lbTerm, upShow is high for exactly one cycle. In that cycle upAddrAck is 1, upAddr and upAttr equal the captured lbAddr and lbAttr, upWrite equals lbWrite, and for a write upData equals the lbWdata sampled with lbValid. Show cycles appear in the same order as the local accesses.
- R4: For a read, upData in the upDataAck cycle equals lbRdata as it was sampled in the lbTerm cycle.
- R5: upErr in the upDataAck cycle equals lbErr as it was sampled in the lbTerm cycle, for reads and for writes alike.
- R6: An access that does not qualify leaves lbHold, upReq and upShow at 0.
- R7: If lbRetry or lbAbort is 1 at the end of a qualifying access, it wins over lbTerm in the same cycle. No upstream request or show cycle follows, and lbHold is 0 in the next cycle.
- R8: upShow rises only in the cycle after a cycle in which upGrant was 1. At most one of upReq, upShow and upDataAck is 1 in any cycle.
- R9: While upNoShow is 1, upReq and upShow are 0. If the indicator arrives in the cycle in which the granted address phase is due, that phase is dropped, and the bridge asks for the bus again once the indicator falls.
- R10: While upInhibit is 1, upReq and upShow are 0. The captured cycle stays pending and is shown after the inhibit falls.
- R11: upDataAck is 1 only in the cycle after a cycle in which upDataGrant was 1.
- R12: busy is 1 from the cycle after a qualifying lbValid until the cycle after upDataAck, or until the cycle after a retry or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lbValid | input | 1 | Local access address phase, one cycle |
| lbWrite | input | 1 | Local access is a write |
| lbAddr | input | ADDR_W | Local access address |
| lbAttr | input | ATTR_W | Local access attributes |
| lbWdata | input | DATA_W | Local write data, valid with lbValid |
| lbTargetUp | input | 1 | Access is directed at the upstream bus |
| lbTargetOwn | input | 1 | Access is directed at the bridge's own registers |
| lbSpr | input | 1 | Access is to a special-purpose register |
| lbTerm | input | 1 | Local data phase terminated normally |
| lbErr | input | 1 | Data error, valid with lbTerm |
| lbRetry | input | 1 | Local access retried |
| lbAbort | input | 1 | Local access aborted |
| lbRdata | input | DATA_W | Local read data, valid with lbTerm |
| lbHold | output | 1 | Bridge holds the local bus |
| enRead | input | 1 | Mirror local reads |
| enWrite | input | 1 | Mirror local writes |
| upReq | output | 1 | Upstream bus request |
| upGrant | input | 1 | Upstream address bus grant |
| upNoShow | input | 1 | Upstream no-show indicator |
| upInhibit | input | 1 | Upstream show activity inhibited |
| upShow | output | 1 | Show-cycle address phase |
| upAddrAck | output | 1 | Bridge's own address-phase acknowledge |
| upAddr | output | ADDR_W | Show-cycle address |
| upAttr | output | ATTR_W | Show-cycle attributes |
| upWrite | output | 1 | Show-cycle direction |
| upDataGrant | input | 1 | Upstream data bus grant |
| upData | output | DATA_W | Write data in the address phase, captured data at termination |
| upDataAck | output | 1 | Data-phase termination strobe |
| upErr | output | 1 | Error status, valid with upDataAck |
| busy | output | 1 | A show cycle is pending or in progress |

## Verification
The sharpest collision is between an upstream grant and the no-show indicator. The no-show can rise in exactly the cycle in which the granted address phase would be driven. The bench's upstream model provokes this by raising upNoShow in the cycle right after it issues the grant. It then judges the outcome by three things: that no show appeared while the indicator was high, that a second grant was needed, and that exactly one show reached the scoreboard with the right contents. A second collision puts a retry or abort in the same cycle as the bridge's first hold cycle. The bench checks that the bridge drops the bus on the following cycle without any upstream activity.

// File: rtl/showcyc_pkg.sv
package showcyc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HOLD_LOCAL,
    S_WAIT_TERM,
    S_REQ_UP,
    S_ADDR_PHASE,
    S_BACKOFF,
    S_DATA_PHASE,
    S_RELEASE
  } scState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capAddr;   // latch address, attributes, direction, write data
    logic capTerm;   // latch error and, for reads, read data
    logic showAddr;  // present the address phase upstream
    logic showTerm;  // present the data-phase termination upstream
  } scCtl_t;

endpackage

// File: rtl/showcyc_data.sv
module showcyc_data
  import showcyc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  scCtl_t            ctl,
  input  logic              lbWrite,
  input  logic [ADDR_W-1:0] lbAddr,
  input  logic [ATTR_W-1:0] lbAttr,
  input  logic [DATA_W-1:0] lbWdata,
  input  logic              lbErr,
  input  logic [DATA_W-1:0] lbRdata,
  output logic [ADDR_W-1:0] upAddr,
  output logic [ATTR_W-1:0] upAttr,
  output logic              upWrite,
  output logic [DATA_W-1:0] upData,
  output logic              upErr
);

  logic [ADDR_W-1:0] addrReg;
  logic [ATTR_W-1:0] attrReg;
  logic [DATA_W-1:0] dataReg;
  logic              writeReg;
  logic              errReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      attrReg  <= '0;
      dataReg  <= '0;
      writeReg <= 1'b0;
      errReg   <= 1'b0;
    end else begin
      if (ctl.capAddr) begin
        addrReg  <= lbAddr;
        attrReg  <= lbAttr;
        writeReg <= lbWrite;
        dataReg  <= lbWdata;
      end
      if (ctl.capTerm) begin
        errReg <= lbErr;
        if (!writeReg) dataReg <= lbRdata;
      end
    end
  end

  always_comb begin
    upAddr  = ctl.showAddr ? addrReg : '0;
    upAttr  = ctl.showAddr ? attrReg : '0;
    upWrite = ctl.showAddr & writeReg;
    upErr   = ctl.showTerm & errReg;
    if (ctl.showTerm || (ctl.showAddr && writeReg)) upData = dataReg;
    else                                            upData = '0;
  end

endmodule

// File: rtl/showcyc_ctrl.sv
module showcyc_ctrl
  import showcyc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   lbValid,
  input  logic   lbWrite,
  input  logic   lbTargetUp,
  input  logic   lbTargetOwn,
  input  logic   lbSpr,
  input  logic   lbTerm,
  input  logic   lbRetry,
  input  logic   lbAbort,
  input  logic   enRead,
  input  logic   enWrite,
  input  logic   upGrant,
  input  logic   upNoShow,
  input  logic   upInhibit,
  input  logic   upDataGrant,
  output scCtl_t ctl,
  output logic   lbHold,
  output logic   upReq,
  output logic   busy
);

  scState_t state, nextState;
  logic     qualify;

  assign qualify = lbValid & ~lbTargetUp & ~lbTargetOwn & ~lbSpr &
                   (lbWrite ? enWrite : enRead);

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    upReq     = 1'b0;
    case (state)
      S_IDLE: begin
        if (qualify) begin
          ctl.capAddr = 1'b1;
          nextState   = S_HOLD_LOCAL;
        end
      end
      S_HOLD_LOCAL, S_WAIT_TERM: begin
        if (lbRetry || lbAbort) begin
          nextState = S_IDLE;
        end else if (lbTerm) begin
          ctl.capTerm = 1'b1;
          nextState   = S_REQ_UP;
        end else begin
          nextState = S_WAIT_TERM;
        end
      end
      S_REQ_UP: begin
        if (upInhibit) begin
          nextState = S_REQ_UP;
        end else if (upNoShow) begin
          nextState = S_BACKOFF;
        end else begin
          upReq = 1'b1;
          if (upGrant) nextState = S_ADDR_PHASE;
        end
      end
      S_ADDR_PHASE: begin
        if (upNoShow || upInhibit) begin
          nextState = S_BACKOFF;
        end else begin
          ctl.showAddr = 1'b1;
          nextState    = S_DATA_PHASE;
        end
      end
      S_BACKOFF: begin
        if (!upNoShow) nextState = S_REQ_UP;
      end
      S_DATA_PHASE: begin
        if (upDataGrant) nextState = S_RELEASE;
      end
      S_RELEASE: begin
        ctl.showTerm = 1'b1;
        nextState    = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign lbHold = (state != S_IDLE);
  assign busy   = (state != S_IDLE);

endmodule

// File: rtl/showcyc_bridge.sv
module showcyc_bridge
  import showcyc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lbValid,
  input  logic              lbWrite,
  input  logic [ADDR_W-1:0] lbAddr,
  input  logic [ATTR_W-1:0] lbAttr,
  input  logic [DATA_W-1:0] lbWdata,
  input  logic              lbTargetUp,
  input  logic              lbTargetOwn,
  input  logic              lbSpr,
  input  logic              lbTerm,
  input  logic              lbErr,
  input  logic              lbRetry,
  input  logic              lbAbort,
  input  logic [DATA_W-1:0] lbRdata,
  output logic              lbHold,
  input  logic              enRead,
  input  logic              enWrite,
  output logic              upReq,
  input  logic              upGrant,
  input  logic              upNoShow,
  input  logic              upInhibit,
  output logic              upShow,
  output logic              upAddrAck,
  output logic [ADDR_W-1:0] upAddr,
  output logic [ATTR_W-1:0] upAttr,
  output logic              upWrite,
  input  logic              upDataGrant,
  output logic [DATA_W-1:0] upData,
  output logic              upDataAck,
  output logic              upErr,
  output logic              busy
);

  scCtl_t ctl;

  showcyc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .lbValid(lbValid), .lbWrite(lbWrite),
    .lbTargetUp(lbTargetUp), .lbTargetOwn(lbTargetOwn), .lbSpr(lbSpr),
    .lbTerm(lbTerm), .lbRetry(lbRetry), .lbAbort(lbAbort),
    .enRead(enRead), .enWrite(enWrite),
    .upGrant(upGrant), .upNoShow(upNoShow), .upInhibit(upInhibit),
    .upDataGrant(upDataGrant),
    .ctl(ctl), .lbHold(lbHold), .upReq(upReq), .busy(busy)
  );

  showcyc_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ATTR_W(ATTR_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .lbWrite(lbWrite), .lbAddr(lbAddr), .lbAttr(lbAttr), .lbWdata(lbWdata),
    .lbErr(lbErr), .lbRdata(lbRdata),
    .upAddr(upAddr), .upAttr(upAttr), .upWrite(upWrite),
    .upData(upData), .upErr(upErr)
  );

  assign upShow    = ctl.showAddr;
  assign upAddrAck = ctl.showAddr;
  assign upDataAck = ctl.showTerm;

endmodule

// File: rtl/showcyc_bridge_chk.sv
module showcyc_bridge_chk (
  input logic clk,
  input logic rstN,
  input logic lbHold,
  input logic upReq,
  input logic upGrant,
  input logic upNoShow,
  input logic upInhibit,
  input logic upShow,
  input logic upDataGrant,
  input logic upDataAck
);

  p_quiet_inhibit_r10: assert property (@(posedge clk) disable iff (!rstN)
    upInhibit |-> (!upReq && !upShow));

  p_noshow_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    upNoShow |-> (!upReq && !upShow));

  p_show_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    upShow |-> $past(upGrant));

  p_phase_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({upReq, upShow, upDataAck}));

  p_ack_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    upDataAck |-> $past(upDataGrant));

  p_hold_cover_r2: assert property (@(posedge clk) disable iff (!rstN)
    (upShow || upDataAck) |-> lbHold);

  p_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    upDataAck |=> !lbHold);

endmodule

bind showcyc_bridge showcyc_bridge_chk u_chk (
  .clk(clk), .rstN(rstN), .lbHold(lbHold), .upReq(upReq), .upGrant(upGrant),
  .upNoShow(upNoShow), .upInhibit(upInhibit), .upShow(upShow),
  .upDataGrant(upDataGrant), .upDataAck(upDataAck)
);

// File: tb/sim_showcyc_bridge.sv
`timescale 1ns/1ps
module sim_showcyc_bridge;

  typedef struct {
    logic [31:0] addr;
    logic [3:0]  attr;
    logic        wr;
    logic [31:0] data;
    logic        err;
  } expItem_t;

  localparam int END_TERM = 0, END_RETRY = 1, END_ABORT = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic lbValid = 0, lbWrite = 0, lbTargetUp = 0, lbTargetOwn = 0, lbSpr = 0;
  logic lbTerm = 0, lbErr = 0, lbRetry = 0, lbAbort = 0;
  logic [31:0] lbAddr = '0, lbWdata = '0, lbRdata = '0;
  logic [3:0]  lbAttr = '0;
  logic enRead = 1, enWrite = 1;
  logic upGrant = 0, upNoShow = 0, upInhibit = 0, upDataGrant = 0;
  logic lbHold, upReq, upShow, upAddrAck, upWrite, upDataAck, upErr, busy;
  logic [31:0] upAddr, upData;
  logic [3:0]  upAttr;

  showcyc_bridge u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int showCount = 0, reqCount = 0, grantCount = 0;
  expItem_t expQ[$];

  // upstream model controls
  bit inhibitReq = 0, nsOnGrant = 0;
  int nsLeft = 0, gDelay = 0, reqRun = 0;
  bit dWait = 0;

  function automatic void chk(input bit ok, input string tag,
                              input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  // upstream model: status inputs at +2, grants at +3
  initial begin
    forever begin
      @(posedge clk);
      #2;
      upInhibit = inhibitReq;
      if (nsOnGrant && upGrant) begin
        upNoShow = 1; nsLeft = 2; nsOnGrant = 0;
      end else if (nsLeft > 0) begin
        upNoShow = 1; nsLeft--;
      end else begin
        upNoShow = 0;
      end
      #1;
      if (upReq) reqRun++; else reqRun = 0;
      if (upReq && reqRun > gDelay) begin
        if (!upGrant) grantCount++;
        upGrant = 1;
      end else begin
        upGrant = 0;
      end
      if (upShow) dWait = 1;
      if (upDataAck) begin dWait = 0; upDataGrant = 0; end
      else if (dWait) upDataGrant = 1;
    end
  end

  // monitor / scoreboard
  logic prevGrant = 0, prevDGrant = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (upReq) reqCount++;
      if (upShow) begin
        showCount++;
        chk(prevGrant, "R8 show without prior grant", 64'(upShow), 64'(prevGrant));
        chk(!upNoShow && !upInhibit, "R9/R10 show while blocked",
            64'({upNoShow, upInhibit}), 64'd0);
        chk(upAddrAck, "R3 address ack", 64'(upAddrAck), 64'd1);
        if (expQ.size() == 0) chk(0, "R3 unexpected show", 64'(upAddr), 64'd0);
        else begin
          chk(upAddr == expQ[0].addr, "R3 addr", 64'(upAddr), 64'(expQ[0].addr));
          chk(upAttr == expQ[0].attr, "R3 attr", 64'(upAttr), 64'(expQ[0].attr));
          chk(upWrite == expQ[0].wr, "R3 direction", 64'(upWrite), 64'(expQ[0].wr));
          if (expQ[0].wr)
            chk(upData == expQ[0].data, "R3 write data", 64'(upData), 64'(expQ[0].data));
        end
      end
      if (upDataAck) begin
        chk(prevDGrant, "R11 ack without data grant", 64'(upDataAck), 64'(prevDGrant));
        chk(lbHold, "R2 hold at ack", 64'(lbHold), 64'd1);
        if (expQ.size() == 0) chk(0, "R4 unexpected ack", 64'(upData), 64'd0);
        else begin
          if (!expQ[0].wr)
            chk(upData == expQ[0].data, "R4 read data", 64'(upData), 64'(expQ[0].data));
          chk(upErr == expQ[0].err, "R5 error status", 64'(upErr), 64'(expQ[0].err));
          void'(expQ.pop_front());
        end
      end
      prevGrant  = upGrant;
      prevDGrant = upDataGrant;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic waitFree();
    for (int i = 0; i < 500 && lbHold; i++) tick();
    chk(!lbHold, "R2 hold released", 64'(lbHold), 64'd0);
  endtask

  // driver: one local access; pushes the expected show cycle
  task automatic access(input bit w, input logic [31:0] a, input logic [3:0] at,
                        input logic [31:0] d, input bit err, input int endKind,
                        input int termDelay, input bit tUp, input bit tOwn,
                        input bit spr);
    bit q;
    expItem_t it;
    while (lbHold) tick();
    q = !tUp && !tOwn && !spr && (w ? enWrite : enRead);
    if (q && endKind == END_TERM) begin
      it.addr = a; it.attr = at; it.wr = w; it.data = d; it.err = err;
      expQ.push_back(it);
    end
    lbValid = 1; lbWrite = w; lbAddr = a; lbAttr = at; lbWdata = w ? d : '0;
    lbTargetUp = tUp; lbTargetOwn = tOwn; lbSpr = spr;
    tick();
    lbValid = 0; lbTargetUp = 0; lbTargetOwn = 0; lbSpr = 0;
    if (q) begin
      chk(lbHold, "R2 hold after qualifying access", 64'(lbHold), 64'd1);
      chk(busy, "R12 busy after qualifying access", 64'(busy), 64'd1);
    end else begin
      chk(!lbHold && !busy, "R6 no hold for filtered access", 64'({lbHold, busy}), 64'd0);
    end
    for (int i = 0; i < termDelay; i++) tick();
    lbTerm  = (endKind == END_TERM);
    lbRetry = (endKind == END_RETRY);
    lbAbort = (endKind == END_ABORT);
    lbErr   = err;
    lbRdata = w ? '0 : d;
    tick();
    lbTerm = 0; lbRetry = 0; lbAbort = 0; lbErr = 0; lbRdata = '0;
    if (q && endKind != END_TERM)
      chk(!lbHold && !busy, "R7 release after retry/abort", 64'({lbHold, busy}), 64'd0);
  endtask

  initial begin
    int s0, r0, g0;
    // R1 reset state
    repeat (3) tick();
    chk({lbHold, busy, upReq, upShow, upAddrAck, upDataAck} == 6'd0,
        "R1 outputs in reset", 64'({lbHold, busy, upReq, upShow, upAddrAck, upDataAck}), 64'd0);
    rstN = 1;
    tick();
    chk({lbHold, busy, upReq, upShow, upAddrAck, upDataAck} == 6'd0,
        "R1 outputs after reset", 64'({lbHold, busy, upReq, upShow, upAddrAck, upDataAck}), 64'd0);

    // R3 write show, immediate termination
    s0 = showCount;
    access(1, 32'h1000_0040, 4'h3, 32'hDEAD_BEEF, 0, END_TERM, 0, 0, 0, 0);
    waitFree();
    chk(showCount == s0 + 1, "R3 one show per write", 64'(showCount - s0), 64'd1);
    chk(!busy, "R12 busy clear after show", 64'(busy), 64'd0);

    // R4/R5 read with error and slow grant
    gDelay = 2;
    s0 = showCount;
    access(0, 32'h2000_1234, 4'hA, 32'hCAFE_F00D, 1, END_TERM, 3, 0, 0, 0);
    waitFree();
    chk(showCount == s0 + 1, "R4 one show per read", 64'(showCount - s0), 64'd1);

    // R5 write with error
    gDelay = 0;
    access(1, 32'h0000_0008, 4'h1, 32'h0123_4567, 1, END_TERM, 1, 0, 0, 0);
    waitFree();

    // R6 filtered accesses
    s0 = showCount; r0 = reqCount;
    access(1, 32'h3000_0000, 4'h2, 32'h1111_1111, 0, END_TERM, 1, 1, 0, 0);
    access(0, 32'h3000_0004, 4'h2, 32'h2222_2222, 0, END_TERM, 0, 0, 1, 0);
    access(0, 32'h3000_0008, 4'h2, 32'h3333_3333, 1, END_TERM, 2, 0, 0, 1);
    enWrite = 0;
    access(1, 32'h3000_000C, 4'h2, 32'h4444_4444, 0, END_TERM, 0, 0, 0, 0);
    enWrite = 1; enRead = 0;
    access(0, 32'h3000_0010, 4'h2, 32'h5555_5555, 0, END_TERM, 0, 0, 0, 0);
    enRead = 1;
    repeat (4) tick();
    chk(showCount == s0 && reqCount == r0, "R6 no upstream activity when filtered",
        64'((showCount - s0) + (reqCount - r0)), 64'd0);

    // R7 retry in the first hold cycle, abort later
    s0 = showCount; r0 = reqCount;
    access(0, 32'h4000_0000, 4'h5, 32'h6666_6666, 0, END_RETRY, 0, 0, 0, 0);
    access(1, 32'h4000_0004, 4'h5, 32'h7777_7777, 0, END_ABORT, 2, 0, 0, 0);
    repeat (4) tick();
    chk(showCount == s0 && reqCount == r0, "R7 no show for retry/abort",
        64'((showCount - s0) + (reqCount - r0)), 64'd0);

    // R9 long no-show while the cycle is pending
    s0 = showCount;
    nsLeft = 12;
    access(1, 32'h5000_0100, 4'h6, 32'h8888_9999, 0, END_TERM, 1, 0, 0, 0);
    tick();
    chk(!upReq, "R9 no request during no-show", 64'(upReq), 64'd0);
    waitFree();
    chk(showCount == s0 + 1, "R9 show after no-show falls", 64'(showCount - s0), 64'd1);

    // R9 no-show in the granted address-phase cycle
    s0 = showCount; g0 = grantCount;
    nsOnGrant = 1;
    access(0, 32'h5000_0200, 4'h7, 32'hAAAA_5555, 0, END_TERM, 0, 0, 0, 0);
    waitFree();
    chk(grantCount - g0 == 2, "R9 re-arbitration after dropped phase",
        64'(grantCount - g0), 64'd2);
    chk(showCount == s0 + 1, "R9 single show after back-off", 64'(showCount - s0), 64'd1);

    // R10/R12 inhibit keeps the cycle pending
    s0 = showCount; r0 = reqCount;
    inhibitReq = 1;
    access(1, 32'h6000_0000, 4'h9, 32'h1357_9BDF, 0, END_TERM, 1, 0, 0, 0);
    repeat (20) tick();
    chk(reqCount == r0 && showCount == s0, "R10 no upstream while inhibited",
        64'((reqCount - r0) + (showCount - s0)), 64'd0);
    chk(lbHold && busy, "R12 busy while show pending", 64'({lbHold, busy}), 64'd3);
    inhibitReq = 0;
    waitFree();
    chk(showCount == s0 + 1, "R10 show after inhibit falls", 64'(showCount - s0), 64'd1);

    // mixed back-to-back traffic
    for (int k = 0; k < 8; k++) begin
      gDelay = k % 3;
      access(k[0], 32'h7000_0000 + 32'(k * 4), 4'(k), 32'hA5A5_0000 + 32'(k),
             k[1], END_TERM, k % 4, 0, 0, 0);
    end
    waitFree();
    repeat (5) tick();
    chk(expQ.size() == 0, "R3 scoreboard drained", 64'(expQ.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule